// File: doc/BRIEF.md
# DMA Channel Control Register File

This block holds the programming state of a four-channel DMA controller. A host processor reaches it over a simple byte-wide bus with a chip select, a 4-bit register address and separate read and write strobes. The block keeps one 6-bit mode field for each channel, a 4-bit channel mask, a 4-bit software request vector, an 8-bit command word, the captured terminal-count flags and a temporary data byte. It drives the mode fields, the mask, the software requests and the command word out to the transfer engine. The engine reports back terminal-count and end-of-process pulses, the byte last moved in a memory-to-memory transfer, and whether it is idle.

The mode and the single-bit mask and request registers are not addressed per channel. The low data bits name the channel instead. End-of-process pulses mask their channel automatically. Terminal-count flags stay set until the host reads the status byte. A write to a dedicated address acts as a master clear and returns every register to its reset state in one cycle. All state, including the read data, is registered. The reset is synchronous and active high.

Top module: `dmac_ctlreg`

## Requirements
- R1: After reset, mode_q is all zero, mask_q is 4'b1111, sreq_q and cmd_q are zero, rdata is zero, and a later status or temporary read returns zero flags and zero data.
- R2: A write to address 1 while idle is high stores wdata[7:2] into the mode field of the channel given by wdata[1:0]. Channel n occupies mode_q[6n+5:6n]. The same write while idle is low changes nothing.
- R3: A write to address 4 loads mask_q with wdata[3:0]. A read of address 4 returns {4'b0000, mask_q}.
- R4: A write to address 3 sets mask_q bit wdata[1:0] when wdata[2] is 1 and clears it when wdata[2] is 0. The other mask bits are unchanged.
- R5: An eop_evt pulse on a channel sets that channel's mask_q bit in the next cycle. The pulse wins over a software write that clears the same bit in the same cycle.
- R6: A write to address 2 sets sreq_q bit wdata[1:0] when wdata[2] is 1 and clears it when wdata[2] is 0.
- R7: A tc_evt pulse captures a per-channel flag. A read of address 6 returns, one cycle later, bits 3:0 = captured flags and bits 7:4 = hw_req OR sreq_q for each channel.
- R8: A status read clears the flags it returned. A tc_evt pulse in the same cycle as the read leaves its flag set for the next read.
- R9: A tmp_ld pulse stores tmp_din. A read of address 7 returns the stored byte when idle is high and zero when idle is low.
- R10: A write to address 0 stores wdata into cmd_q. A read of address 0 returns it.
- R11: A write to address 5 is a master clear. In the next cycle every register holds its reset value, and the clear takes priority over concurrent tc_evt, eop_evt and tmp_ld pulses.
- R12: rdata is zero in any cycle that follows a cycle without a read, and after a read of an unmapped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| idle | input | 1 | Transfer engine is idle |
| hw_req | input | 4 | Hardware request per channel |
| tc_evt | input | 4 | Terminal-count pulse per channel |
| eop_evt | input | 4 | End-of-process pulse per channel |
| tmp_ld | input | 1 | Load the temporary byte |
| tmp_din | input | 8 | Byte moved in memory-to-memory transfer |
| mode_q | output | 24 | Mode fields, 6 bits per channel |
| mask_q | output | 4 | Channel mask vector |
| sreq_q | output | 4 | Software request vector |
| cmd_q | output | 8 | Command word |

## Verification
The bench targets the cycles in which two sources touch one bit. An end-of-process pulse paired with a software clear of the same mask bit catches a design that gives the write priority: that channel would stay unmasked. A terminal-count pulse landing on a status read catches a design that lets the clear win: the count would be lost and never reach the next read. A mode write while busy and a temporary read while busy catch missing idle qualification, which would show up as a changed mode field or leaked data. A master clear issued together with event pulses catches a clear that does not take full priority, which would leave a flag, a mask bit or the temporary byte in the wrong state.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CMD    = 4'd0;
  localparam logic [ADDR_W-1:0] A_MODE   = 4'd1;
  localparam logic [ADDR_W-1:0] A_REQ1   = 4'd2;
  localparam logic [ADDR_W-1:0] A_MSK1   = 4'd3;
  localparam logic [ADDR_W-1:0] A_MSKALL = 4'd4;
  localparam logic [ADDR_W-1:0] A_MCLR   = 4'd5;
  localparam logic [ADDR_W-1:0] A_STAT   = 4'd6;
  localparam logic [ADDR_W-1:0] A_TEMP   = 4'd7;
endpackage

// File: rtl/dmac_modefile.sv
module dmac_modefile #(
  parameter int NCH = 4,
  parameter int MW  = 6,
  parameter int DW  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              we,
  input  logic [DW-1:0]     wdata,
  output logic [NCH*MW-1:0] mode_q
);
  localparam int CW = $clog2(NCH);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst || clr)
        mode_q[i*MW +: MW] <= '0;
      else if (we && wdata[CW-1:0] == CW'(i))
        mode_q[i*MW +: MW] <= wdata[CW +: MW];
    end
  end
endmodule

// File: rtl/dmac_maskreq.sv
module dmac_maskreq #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           all_we,
  input  logic           msk1_we,
  input  logic           req1_we,
  input  logic [DW-1:0]  wdata,
  input  logic [NCH-1:0] eop_evt,
  output logic [NCH-1:0] mask_q,
  output logic [NCH-1:0] sreq_q
);
  localparam int CW = $clog2(NCH);

  logic           val;
  logic [CW-1:0]  sel;
  assign val = wdata[CW];
  assign sel = wdata[CW-1:0];

  for (genvar i = 0; i < NCH; i++) begin : g_bit
    logic hit;
    assign hit = (sel == CW'(i));

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        mask_q[i] <= 1'b1;
      end else if (eop_evt[i]) begin
        mask_q[i] <= 1'b1;
      end else if (all_we) begin
        mask_q[i] <= wdata[i];
      end else if (msk1_we && hit) begin
        mask_q[i] <= val;
      end
    end

    always_ff @(posedge clk) begin
      if (rst || clr)
        sreq_q[i] <= 1'b0;
      else if (req1_we && hit)
        sreq_q[i] <= val;
    end
  end
endmodule

// File: rtl/dmac_tcstat.sv
module dmac_tcstat #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           stat_rd,
  input  logic [NCH-1:0] tc_evt,
  input  logic           tmp_ld,
  input  logic [DW-1:0]  tmp_din,
  output logic [NCH-1:0] tc_q,
  output logic [DW-1:0]  temp_q
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      tc_q <= '0;
    else
      tc_q <= (stat_rd ? '0 : tc_q) | tc_evt;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      temp_q <= '0;
    else if (tmp_ld)
      temp_q <= tmp_din;
  end
endmodule

// File: rtl/dmac_ctlreg.sv
module dmac_ctlreg
  import dmac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int MW  = 6,
  parameter int DW  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs,
  input  logic                    wr,
  input  logic                    rd,
  input  logic [dmac_pkg::ADDR_W-1:0] addr,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata,
  input  logic                    idle,
  input  logic [NCH-1:0]          hw_req,
  input  logic [NCH-1:0]          tc_evt,
  input  logic [NCH-1:0]          eop_evt,
  input  logic                    tmp_ld,
  input  logic [DW-1:0]           tmp_din,
  output logic [NCH*MW-1:0]       mode_q,
  output logic [NCH-1:0]          mask_q,
  output logic [NCH-1:0]          sreq_q,
  output logic [DW-1:0]           cmd_q
);
  logic          wr_en, rd_en, mclr;
  logic [NCH-1:0] tc_q;
  logic [DW-1:0]  temp_q;
  logic [DW-1:0]  rd_mux;

  assign wr_en = cs && wr;
  assign rd_en = cs && rd;
  assign mclr  = wr_en && (addr == A_MCLR);

  dmac_modefile #(.NCH(NCH), .MW(MW), .DW(DW)) u_mode (
    .clk(clk), .rst(rst), .clr(mclr),
    .we(wr_en && addr == A_MODE && idle),
    .wdata(wdata), .mode_q(mode_q)
  );

  dmac_maskreq #(.NCH(NCH), .DW(DW)) u_mskreq (
    .clk(clk), .rst(rst), .clr(mclr),
    .all_we(wr_en && addr == A_MSKALL),
    .msk1_we(wr_en && addr == A_MSK1),
    .req1_we(wr_en && addr == A_REQ1),
    .wdata(wdata), .eop_evt(eop_evt),
    .mask_q(mask_q), .sreq_q(sreq_q)
  );

  dmac_tcstat #(.NCH(NCH), .DW(DW)) u_stat (
    .clk(clk), .rst(rst), .clr(mclr),
    .stat_rd(rd_en && addr == A_STAT),
    .tc_evt(tc_evt), .tmp_ld(tmp_ld), .tmp_din(tmp_din),
    .tc_q(tc_q), .temp_q(temp_q)
  );

  always_ff @(posedge clk) begin
    if (rst || mclr)
      cmd_q <= '0;
    else if (wr_en && addr == A_CMD)
      cmd_q <= wdata;
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CMD:    rd_mux = cmd_q;
      A_MSKALL: rd_mux = DW'(mask_q);
      A_STAT:   rd_mux = DW'({hw_req | sreq_q, tc_q});
      A_TEMP:   rd_mux = idle ? temp_q : '0;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else
      rdata <= rd_en ? rd_mux : '0;
  end
endmodule

// File: rtl/dmac_ctlreg_chk.sv
module dmac_ctlreg_chk
  import dmac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int MW  = 6,
  parameter int DW  = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cs,
  input logic                    wr,
  input logic                    rd,
  input logic [dmac_pkg::ADDR_W-1:0] addr,
  input logic [DW-1:0]           rdata,
  input logic                    idle,
  input logic [NCH-1:0]          tc_evt,
  input logic [NCH-1:0]          eop_evt,
  input logic [NCH*MW-1:0]       mode_q,
  input logic [NCH-1:0]          mask_q,
  input logic [NCH-1:0]          sreq_q,
  input logic [DW-1:0]           cmd_q,
  input logic [NCH-1:0]          tc_q
);
  assert_mode_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == A_MODE && !idle) |=> $stable(mode_q));

  assert_eop_masks_R5: assert property (@(posedge clk) disable iff (rst)
    (|eop_evt) |=> ((mask_q & $past(eop_evt)) == $past(eop_evt)));

  assert_stat_flags_R7: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && addr == A_STAT) |=> (rdata[NCH-1:0] == $past(tc_q)));

  assert_tc_kept_R8: assert property (@(posedge clk) disable iff (rst)
    ((|tc_evt) && !(cs && wr && addr == A_MCLR)) |=> ((tc_q & $past(tc_evt)) == $past(tc_evt)));

  assert_mclr_R11: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == A_MCLR) |=>
      (mask_q == '1 && sreq_q == '0 && mode_q == '0 && cmd_q == '0 && tc_q == '0));

  assert_rdata_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !(cs && rd) |=> (rdata == '0));
endmodule

bind dmac_ctlreg dmac_ctlreg_chk #(.NCH(NCH), .MW(MW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
  .rdata(rdata), .idle(idle), .tc_evt(tc_evt), .eop_evt(eop_evt),
  .mode_q(mode_q), .mask_q(mask_q), .sreq_q(sreq_q), .cmd_q(cmd_q),
  .tc_q(tc_q)
);

// File: tb/dmac_ctlreg_test.sv
module dmac_ctlreg_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs = 0, wr = 0, rd = 0, idle = 1, tmp_ld = 0;
  logic [3:0]  addr = 0, hw_req = 0, tc_evt = 0, eop_evt = 0;
  logic [7:0]  wdata = 0, tmp_din = 0;
  logic [7:0]  rdata, cmd_q;
  logic [23:0] mode_q;
  logic [3:0]  mask_q, sreq_q;

  int checks = 0, fails = 0;
  bit chk_on = 0;
  string tag = "R1";

  // reference state
  logic [5:0] m_mode [4];
  logic [3:0] m_mask, m_sreq, m_tc;
  logic [7:0] m_temp, m_cmd, m_rdata;

  always #10 clk = ~clk;

  dmac_ctlreg uut (
    .clk(clk), .rst(rst), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
    .wdata(wdata), .rdata(rdata), .idle(idle), .hw_req(hw_req),
    .tc_evt(tc_evt), .eop_evt(eop_evt), .tmp_ld(tmp_ld), .tmp_din(tmp_din),
    .mode_q(mode_q), .mask_q(mask_q), .sreq_q(sreq_q), .cmd_q(cmd_q)
  );

  task automatic clear_model();
    for (int i = 0; i < 4; i++) m_mode[i] = '0;
    m_mask = 4'hF; m_sreq = 0; m_tc = 0; m_temp = 0; m_cmd = 0;
  endtask

  always @(posedge clk) begin
    logic [7:0] nr;
    nr = 0;
    if (cs && rd) begin
      case (addr)
        4'd0: nr = m_cmd;
        4'd4: nr = {4'b0, m_mask};
        4'd6: nr = {hw_req | m_sreq, m_tc};
        4'd7: nr = idle ? m_temp : 8'h00;
        default: nr = 0;
      endcase
    end
    if (rst) begin
      clear_model(); m_rdata = 0;
    end else if (cs && wr && addr == 4'd5) begin
      clear_model(); m_rdata = nr;
    end else begin
      m_rdata = nr;
      if (cs && rd && addr == 4'd6) m_tc = 0;
      m_tc = m_tc | tc_evt;
      if (tmp_ld) m_temp = tmp_din;
      if (cs && wr) begin
        case (addr)
          4'd0: m_cmd = wdata;
          4'd1: if (idle) m_mode[wdata[1:0]] = wdata[7:2];
          4'd2: m_sreq[wdata[1:0]] = wdata[2];
          4'd3: m_mask[wdata[1:0]] = wdata[2];
          4'd4: m_mask = wdata[3:0];
          default: ;
        endcase
      end
      m_mask = m_mask | eop_evt;
    end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      check("mode_q", 32'(mode_q), 32'({m_mode[3], m_mode[2], m_mode[1], m_mode[0]}));
      check("mask_q", 32'(mask_q), 32'(m_mask));
      check("sreq_q", 32'(sreq_q), 32'(m_sreq));
      check("cmd_q",  32'(cmd_q),  32'(m_cmd));
      check("rdata",  32'(rdata),  32'(m_rdata));
    end
  end

  task automatic bus(input logic w, input logic r, input logic [3:0] a, input logic [7:0] d);
    cs = 1; wr = w; rd = r; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; wr = 0; rd = 0; addr = 0; wdata = 0;
    tc_evt = 0; eop_evt = 0; tmp_ld = 0;
  endtask

  task automatic idle_cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tc_evt = 0; eop_evt = 0; tmp_ld = 0;
    end
  endtask

  initial begin
    #4_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; chk_on = 1;
    tag = "R1"; idle_cyc(2); bus(0, 1, 4'd6, 0); bus(0, 1, 4'd7, 0); bus(0, 1, 4'd4, 0); idle_cyc(1);

    tag = "R10"; bus(1, 0, 4'd0, 8'hA5); bus(0, 1, 4'd0, 0); idle_cyc(1);

    tag = "R2";
    for (int c = 0; c < 4; c++) bus(1, 0, 4'd1, {6'(6'h15 + c * 9), 2'(c)});
    idle = 0; bus(1, 0, 4'd1, 8'hFE); idle_cyc(1); idle = 1; idle_cyc(1);

    tag = "R3"; bus(1, 0, 4'd4, 8'h00); bus(0, 1, 4'd4, 0); bus(1, 0, 4'd4, 8'hF9); bus(0, 1, 4'd4, 0);
    idle_cyc(1);
    tag = "R4"; bus(1, 0, 4'd3, 8'h06); bus(1, 0, 4'd3, 8'h00); bus(1, 0, 4'd3, 8'h03); idle_cyc(1);

    tag = "R5"; bus(1, 0, 4'd4, 8'h00);
    eop_evt = 4'b0010; idle_cyc(1);
    eop_evt = 4'b1000; bus(1, 0, 4'd3, 8'h03);
    eop_evt = 4'b0100; bus(1, 0, 4'd4, 8'h00); idle_cyc(1);

    tag = "R6"; bus(1, 0, 4'd2, 8'h05); bus(1, 0, 4'd2, 8'h07); bus(1, 0, 4'd2, 8'h01); idle_cyc(1);

    tag = "R7"; hw_req = 4'b1000; tc_evt = 4'b0101; idle_cyc(1);
    bus(0, 1, 4'd6, 0); idle_cyc(1);
    tag = "R8"; tc_evt = 4'b0010; bus(0, 1, 4'd6, 0); bus(0, 1, 4'd6, 0); bus(0, 1, 4'd6, 0);
    hw_req = 0; idle_cyc(1);

    tag = "R9"; tmp_din = 8'h3C; tmp_ld = 1; idle_cyc(1);
    bus(0, 1, 4'd7, 0); idle = 0; bus(0, 1, 4'd7, 0); idle = 1; idle_cyc(1);

    tag = "R11"; tc_evt = 4'hF; eop_evt = 4'h1; tmp_din = 8'h77; tmp_ld = 1;
    bus(1, 0, 4'd5, 0); bus(0, 1, 4'd6, 0); bus(0, 1, 4'd7, 0); idle_cyc(1);

    tag = "R12"; bus(0, 1, 4'd9, 0); idle_cyc(1);
    for (int k = 0; k < 400; k++) begin
      int op;
      op = int'($urandom_range(0, 3));
      idle = ($urandom_range(0, 3) != 0);
      hw_req = 4'($urandom); tc_evt = 4'($urandom) & 4'($urandom);
      eop_evt = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0;
      tmp_ld = ($urandom_range(0, 3) == 0); tmp_din = 8'($urandom);
      if (op == 0) idle_cyc(1);
      else if (op == 1) bus(0, 1, 4'($urandom_range(0, 9)), 0);
      else begin
        logic [3:0] a;
        a = 4'($urandom_range(0, 4));
        if ($urandom_range(0, 40) == 0) a = 4'd5;
        bus(1, 0, a, 8'($urandom));
      end
    end
    idle_cyc(2);
    chk_on = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule